// File: doc/BRIEF.md
# Reverse Nibble-Mode Host Receiver

This block is the host end of the reverse channel of a parallel port working in nibble mode. When software asks for a number of bytes, it walks the peripheral through one four-step handshake per nibble on the host-acknowledge line. It builds each nibble from four status lines, joins two nibbles into a byte (low half first) and hands each byte to the downstream logic over a valid/ready port.

The peripheral it serves does not signal "more data" between bytes. The receiver therefore looks at the error line only once, before the first nibble. If that first look finds no data, the transfer ends at once with zero bytes and the host-acknowledge line is left low, which is the reverse-idle level. Each handshake wait has a programmable limit in clock cycles. If the limit is reached, the transfer stops and reports the whole bytes received so far. After a full-length transfer, the error line is read one more time and the result is reported as "peripheral still has data" or "peripheral is empty". All status inputs pass through a two-flop synchronizer before use.

Top module: `nibble_rev_rx`

## Requirements
- R1: After reset, host_ack_n is high, out_valid is low, busy is low and done is low.
- R2: For each nibble the block drives host_ack_n low, waits for st_ack low, samples the nibble, drives host_ack_n high, then waits for st_ack high. It makes exactly two such handshakes per byte delivered.
- R3: The nibble is formed as bit0 = st_err, bit1 = st_sel, bit2 = st_paper and bit3 = NOT st_busy, where st_busy is the status-register busy bit. The first nibble of a byte is placed in bits 3:0 and the second in bits 7:4.
- R4: st_err is examined only before the first nibble. If it is high there, no handshake runs and the transfer ends with rx_count = 0 and flag_nodata = 1, with host_ack_n left low. A high st_err during later nibbles is treated as data.
- R5: If st_ack does not fall within timeout_cycles, the transfer ends with flag_timeout = 1 and host_ack_n high, and rx_count holds the number of complete bytes.
- R6: If st_ack does not rise within timeout_cycles, the transfer ends with flag_timeout = 1, and rx_count counts only complete bytes.
- R7: When byte_count bytes have been delivered, st_err is sampled once more, and tail_avail is set to 1 if it was low and to 0 if it was high.
- R8: While out_valid is high and out_ready is low, out_data holds steady and host_ack_n stays high, so no new handshake begins.
- R9: done is a one-cycle pulse at the end of every transfer, and rx_count then equals the number of bytes accepted on the output. A byte_count of 0 completes with no handshake and with the tail sample of R7.
- R10: A start pulse while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| byte_count | input | CNT_W | Bytes to read |
| timeout_cycles | input | TMO_W | Limit for each handshake wait |
| st_err | input | 1 | Peripheral error line (data-available when low; nibble bit 0) |
| st_sel | input | 1 | Select line (nibble bit 1) |
| st_paper | input | 1 | Paper-end line (nibble bit 2) |
| st_ack | input | 1 | Peripheral acknowledge line level |
| st_busy | input | 1 | Status-register busy bit (nibble bit 3 inverted) |
| host_ack_n | output | 1 | Host acknowledge line level, low = asserted |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Assembled byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_count | output | CNT_W | Complete bytes received in the last transfer |
| flag_timeout | output | 1 | Last transfer ended on a handshake timeout |
| flag_nodata | output | 1 | Last transfer found no data at the first check |
| tail_avail | output | 1 | Error line was low at the end-of-transfer sample |

## Verification
Byte patterns are chosen so that every status line takes both levels in each nibble position. This separates a swapped or uninverted line, and swapped nibble halves. Some patterns put the error line high in the middle of a transfer, which catches any re-check of data-available between bytes. The same patterns are run with the output always ready, ready one cycle in three, and ready held off for a long stretch. These show whether back-pressure stops the handshake and keeps the byte steady. Directed runs cover a peripheral that never drops or never raises its acknowledge, a peripheral that reports no data at the start, a zero-length request and a start pulse during a busy transfer.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_WLO, S_WHI, S_HOLD, S_FIN, S_DONE
  } nrx_state_t;

  // status lines -> nibble: err, sel, paper straight; busy register bit inverted
  function automatic logic [3:0] nib_from_status(input logic err, input logic sel,
                                                 input logic paper, input logic busy_reg);
    return {~busy_reg, paper, sel, err};
  endfunction

  // first-received nibble occupies the low half
  function automatic logic [7:0] byte_join(input logic [3:0] first, input logic [3:0] second);
    return {second, first};
  endfunction

endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nrx_wait_timer.sv
module nrx_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nibble_rev_rx.sv
module nibble_rev_rx
  import nrx_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [TMO_W-1:0] timeout_cycles,
  input  logic             st_err,
  input  logic             st_sel,
  input  logic             st_paper,
  input  logic             st_ack,
  input  logic             st_busy,
  output logic             host_ack_n,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] rx_count,
  output logic             flag_timeout,
  output logic             flag_nodata,
  output logic             tail_avail
);
  localparam int NST = 5;
  localparam logic [NST-1:0] ST_RST = 5'b00010; // ack line idles high

  logic [NST-1:0] st_raw, st_s;
  logic err_s, sel_s, paper_s, ack_s, busy_s;

  assign st_raw = {st_err, st_sel, st_paper, st_ack, st_busy};
  assign {err_s, sel_s, paper_s, ack_s, busy_s} = st_s;

  nrx_sync #(.W(NST), .RST_VAL(ST_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(st_raw), .q(st_s)
  );

  nrx_state_t       st;
  logic [CNT_W-1:0] tgt, rcvd;
  logic [3:0]       lo_nib, cur_nib;
  logic             half, hack_q, ov_q, done_q, tmo_q, nodata_q, tail_q;
  logic [7:0]       od_q;

  // named events for the checks
  logic ev_ack_lo, ev_ack_hi, ev_nib_take, ev_byte_push, ev_accept, tmr_exp, waiting;

  assign waiting      = (st == S_WLO) || (st == S_WHI);
  assign ev_ack_lo    = (st == S_WLO) && !ack_s;
  assign ev_ack_hi    = (st == S_WHI) && ack_s;
  assign ev_nib_take  = ev_ack_lo;
  assign ev_byte_push = ev_ack_hi && half;
  assign ev_accept    = ov_q && out_ready;

  nrx_wait_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(!waiting || ev_ack_lo || ev_ack_hi),
    .run(waiting), .limit(timeout_cycles), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tgt      <= '0;
      rcvd     <= '0;
      lo_nib   <= '0;
      cur_nib  <= '0;
      half     <= 1'b0;
      hack_q   <= 1'b1;
      ov_q     <= 1'b0;
      od_q     <= '0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      nodata_q <= 1'b0;
      tail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_accept) ov_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          tgt      <= byte_count;
          rcvd     <= '0;
          half     <= 1'b0;
          tmo_q    <= 1'b0;
          nodata_q <= 1'b0;
          tail_q   <= 1'b0;
          st       <= S_CHECK;
        end
        S_CHECK: begin
          if (tgt == '0) st <= S_FIN;
          else if (err_s) begin       // nothing to send: park at reverse idle
            nodata_q <= 1'b1;
            hack_q   <= 1'b0;
            st       <= S_DONE;
          end else begin
            hack_q <= 1'b0;
            st     <= S_WLO;
          end
        end
        S_WLO: begin
          if (ev_ack_lo) begin
            cur_nib <= nib_from_status(err_s, sel_s, paper_s, busy_s);
            hack_q  <= 1'b1;
            st      <= S_WHI;
          end else if (tmr_exp) begin
            hack_q <= 1'b1;
            tmo_q  <= 1'b1;
            st     <= S_DONE;
          end
        end
        S_WHI: begin
          if (ev_ack_hi) begin
            if (!half) begin
              lo_nib <= cur_nib;
              half   <= 1'b1;
              hack_q <= 1'b0;
              st     <= S_WLO;
            end else begin
              od_q <= byte_join(lo_nib, cur_nib);
              ov_q <= 1'b1;
              rcvd <= rcvd + 1'b1;
              half <= 1'b0;
              st   <= S_HOLD;
            end
          end else if (tmr_exp) begin
            tmo_q <= 1'b1;
            st    <= S_DONE;
          end
        end
        S_HOLD: if (ev_accept) begin
          if (rcvd == tgt) st <= S_FIN;
          else begin
            hack_q <= 1'b0;
            st     <= S_WLO;
          end
        end
        S_FIN: begin
          tail_q <= !err_s;
          st     <= S_DONE;
        end
        S_DONE: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign host_ack_n   = hack_q;
  assign out_valid    = ov_q;
  assign out_data     = od_q;
  assign busy         = (st != S_IDLE);
  assign done         = done_q;
  assign rx_count     = rcvd;
  assign flag_timeout = tmo_q;
  assign flag_nodata  = nodata_q;
  assign tail_avail   = tail_q;

  AST_TAKE_WHILE_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nib_take |-> !host_ack_n); // R2
  AST_PUSH_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_push |-> host_ack_n && ack_s); // R2
  AST_NODATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_nodata) |-> (rx_count == '0) && !host_ack_n); // R4
  AST_TMO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_timeout) |-> host_ack_n); // R5
  AST_STALL_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> host_ack_n); // R8
  AST_STALL_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rx_count <= tgt); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st != S_DONE) |=> $stable(tgt)); // R10

endmodule

// File: tb/test_nibble_rev_rx.sv
`timescale 1ns/1ps
module test_nibble_rev_rx;
  localparam int CNT_W = 8;
  localparam int TMO_W = 16;
  localparam int TMO   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [TMO_W-1:0] timeout_cycles = TMO_W'(TMO);
  logic st_err = 1'b0, st_sel = 1'b0, st_paper = 1'b0, st_ack = 1'b1, st_busy = 1'b0;
  logic host_ack_n, out_valid, out_ready, busy, done, flag_timeout, flag_nodata, tail_avail;
  logic [7:0] out_data;
  logic [CNT_W-1:0] rx_count;

  always #2 clk = ~clk; // 250 MHz

  nibble_rev_rx #(.CNT_W(CNT_W), .TMO_W(TMO_W)) i_nibble_rev_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .timeout_cycles(timeout_cycles), .st_err(st_err), .st_sel(st_sel),
    .st_paper(st_paper), .st_ack(st_ack), .st_busy(st_busy),
    .host_ack_n(host_ack_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .done(done), .rx_count(rx_count),
    .flag_timeout(flag_timeout), .flag_nodata(flag_nodata), .tail_avail(tail_avail)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // peripheral model state
  logic [3:0] pr_nib [0:15];
  int  pr_n = 0, pr_idx = 0, pr_hi_stop = -1;
  logic pr_tail = 1'b0;
  int  host_lows = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && host_ack_n == 1'b0 && st_ack == 1'b1 && pr_idx < pr_n) begin
        // R3 encoding: bit0 err, bit1 sel, bit2 paper, bit3 = NOT busy
        st_err   = pr_nib[pr_idx][0];
        st_sel   = pr_nib[pr_idx][1];
        st_paper = pr_nib[pr_idx][2];
        st_busy  = ~pr_nib[pr_idx][3];
        st_ack   = 1'b0;
        host_lows++;
      end else if (rst_n && host_ack_n == 1'b1 && st_ack == 1'b0 && pr_idx != pr_hi_stop) begin
        st_ack = 1'b1;
        pr_idx++;
        if (pr_idx == pr_n) st_err = pr_tail;
      end
    end
  end

  // sink: ready pattern, byte capture, stall watch
  int rdy_mode = 0, rdy_cnt = 0, got_n = 0, stall_viol = 0;
  logic [7:0] got [0:15];
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      rdy_cnt++;
      case (rdy_mode)
        1:       out_ready = (rdy_cnt % 3 == 0);
        2:       out_ready = (rdy_cnt >= 60);
        default: out_ready = 1'b1;
      endcase
      if (out_valid && !out_ready && !host_ack_n) stall_viol++;
      if (out_valid && out_ready && got_n < 16) begin
        got[got_n] = out_data;
        got_n++;
      end
    end
  end

  task automatic load_bytes(input logic [7:0] b [0:3], input int nb, input logic tail);
    for (int k = 0; k < nb; k++) begin
      pr_nib[2*k]   = b[k][3:0];
      pr_nib[2*k+1] = b[k][7:4];
    end
    pr_n = 2 * nb; pr_idx = 0; pr_tail = tail; pr_hi_stop = -1;
    host_lows = 0; got_n = 0; stall_viol = 0; rdy_cnt = 0;
  endtask

  task automatic fire(input int cnt);
    @(negedge clk);
    byte_count = CNT_W'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  bit done_seen;
  task automatic wait_done();
    done_seen = 1'b0;
    for (int c = 0; c < 5000 && !done_seen; c++) begin
      @(negedge clk);
      if (done) done_seen = 1'b1;
    end
    chk(done_seen, "R9 done seen", int'(done_seen), 1);
  endtask

  task automatic line_rest();
    st_err = 1'b0; st_sel = 1'b0; st_paper = 1'b0; st_busy = 1'b0; st_ack = 1'b1;
    pr_n = 0; pr_idx = 0; pr_hi_stop = -1;
    repeat (4) @(negedge clk);
  endtask

  // vector: [47:40] count, [39:8] bytes b0..b3, [4] tail err, [1:0] ready mode
  localparam int NV = 4;
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'd1, 8'hA5, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0},
    {8'd4, 8'h00, 8'hFF, 8'h3C, 8'hC3, 4'h1, 4'h0},
    {8'd3, 8'h5A, 8'h81, 8'h7E, 8'h00, 4'h0, 4'h1},
    {8'd2, 8'h0F, 8'hF0, 8'h00, 8'h00, 4'h1, 4'h2}
  };

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] bb [0:3];
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(host_ack_n == 1'b1, "R1 host_ack_n", int'(host_ack_n), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table of vectors: R2 R3 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      n = int'(VEC[v][47:40]);
      bb[0] = VEC[v][39:32]; bb[1] = VEC[v][31:24];
      bb[2] = VEC[v][23:16]; bb[3] = VEC[v][15:8];
      rdy_mode = int'(VEC[v][1:0]);
      load_bytes(bb, n, VEC[v][4]);
      fire(n);
      wait_done();
      chk(int'(rx_count) == n, "R9 rx_count", int'(rx_count), n);
      chk(got_n == n, "R9 bytes delivered", got_n, n);
      for (int k = 0; k < n; k++)
        chk(got[k] == bb[k], "R3 byte value", int'(got[k]), int'(bb[k]));
      chk(host_lows == 2 * n, "R2 handshakes", host_lows, 2 * n);
      chk(tail_avail == !VEC[v][4], "R7 tail_avail", int'(tail_avail), int'(!VEC[v][4]));
      chk(!flag_timeout && !flag_nodata, "R4 flags clear", int'({flag_timeout, flag_nodata}), 0);
      chk(stall_viol == 0, "R8 no handshake during stall", stall_viol, 0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
      rdy_mode = 0;
      line_rest();
    end

    // R4 no data at first check
    bb[0] = 8'h11; load_bytes(bb, 0, 1'b0);
    st_err = 1'b1;
    repeat (3) @(negedge clk);
    fire(3);
    wait_done();
    chk(flag_nodata == 1'b1, "R4 flag_nodata", int'(flag_nodata), 1);
    chk(rx_count == 0 && got_n == 0, "R4 zero bytes", int'(rx_count), 0);
    chk(host_ack_n == 1'b0, "R4 reverse idle level", int'(host_ack_n), 0);
    chk(host_lows == 0, "R4 no handshake", host_lows, 0);
    line_rest();

    // R9 / R7 zero length with error low
    load_bytes(bb, 0, 1'b0);
    fire(0);
    wait_done();
    chk(rx_count == 0 && !flag_timeout && !flag_nodata, "R9 zero length", int'(rx_count), 0);
    chk(tail_avail == 1'b1, "R7 tail on zero length", int'(tail_avail), 1);
    line_rest();

    // R5 timeout waiting for ack low: peripheral has only two bytes
    bb[0] = 8'h21; bb[1] = 8'h43;
    load_bytes(bb, 2, 1'b0);
    fire(3);
    wait_done();
    chk(flag_timeout == 1'b1, "R5 flag_timeout", int'(flag_timeout), 1);
    chk(rx_count == 2 && got_n == 2, "R5 complete bytes", int'(rx_count), 2);
    chk(host_ack_n == 1'b1, "R5 host_ack_n released", int'(host_ack_n), 1);
    line_rest();

    // R6 timeout waiting for ack high during second nibble
    bb[0] = 8'h99;
    load_bytes(bb, 2, 1'b0);
    pr_hi_stop = 1;
    fire(2);
    wait_done();
    chk(flag_timeout == 1'b1, "R6 flag_timeout", int'(flag_timeout), 1);
    chk(rx_count == 0 && got_n == 0, "R6 partial byte dropped", int'(rx_count), 0);
    line_rest();

    // R10 start while busy is ignored
    bb[0] = 8'h12; bb[1] = 8'h34;
    load_bytes(bb, 2, 1'b0);
    rdy_mode = 2;
    fire(2);
    repeat (10) @(negedge clk);
    fire(7);
    wait_done();
    chk(rx_count == 2 && !flag_timeout, "R10 second start ignored", int'(rx_count), 2);
    chk(got_n == 2 && got[1] == 8'h34, "R10 bytes intact", int'(got[1]), 'h34);
    rdy_mode = 0;
    line_rest();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule